// File: doc/BRIEF.md
# Synchronous FIFO-bridge read master

This block is the reading side of a master that empties a 16-bit synchronous slave FIFO inside a bridge chip. It drives three active-low, registered control pins: chip select, output enable and read strobe. It also watches the bridge's watermark flag, which stays high while more than a fixed number of words remain in the bridge. Each word the bridge launches lands on the data bus a fixed number of clocks after the strobe was sampled low. The block captures that word and hands it to a downstream valid/ready stream.

A burst starts only when the watermark flag is high and the downstream sink is ready. The block then strobes one word per clock until it samples the flag low. After that it keeps strobing for a set number of extra words that the bridge still holds. It then releases the strobe, but holds select and output enable low long enough for the words still in the bridge's pipeline to be driven and captured. Only then does it return to idle.

Back-pressure rule: `m_ready_i` is consulted only at the clock edge that starts a burst, because strobes already issued cannot be recalled. A sink that has granted a burst must keep `m_ready_i` high until `cs_n_o` is high and `m_valid_o` is low. Under that rule every `m_valid_o` beat is accepted in the cycle it appears. `m_valid_o` is high for exactly one cycle per word.

Top module: `fbr_read_master`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `cs_n_o`, `oe_n_o` and `rd_n_o` are 1 and `m_valid_o` is 0.
- R2: `cs_n_o`, `oe_n_o` and `rd_n_o` fall together, and only at a clock edge where both `wm_flag_i` and `m_ready_i` were high. With `m_ready_i` low, no burst starts even if the flag is high.
- R3: Whenever `rd_n_o` is 0, `cs_n_o` and `oe_n_o` are also 0.
- R4: For every clock edge at which `rd_n_o` and `cs_n_o` are sampled 0, the value on `bus_data_i` at the LATENCY-th following edge (default 2) appears on `m_data_o`, with `m_valid_o` high for the cycle after that edge. `m_valid_o` is high at no other time.
- R5: Counting from the first edge of a burst at which `wm_flag_i` is sampled low (inclusive), exactly SLACK_WORDS strobes (default 2) are sampled before `rd_n_o` returns to 1.
- R6: `cs_n_o` and `oe_n_o` return to 1 exactly LATENCY clock edges after the edge at which `rd_n_o` returns to 1.
- R7: Across repeated bursts, every word the bridge launches reaches the stream exactly once and in order. The master never strobes a word the bridge does not hold.
- R8: A change of `wm_flag_i` after the burst's tail has begun does not alter the tail or release timing. `cs_n_o` stays high for at least one full cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the bridge |
| rst | input | 1 | Synchronous reset, active high |
| wm_flag_i | input | 1 | Watermark flag from the bridge, high while more than SLACK_WORDS words remain |
| bus_data_i | input | DATA_W | Read data bus driven by the bridge |
| cs_n_o | output | 1 | Chip select, active low, registered |
| oe_n_o | output | 1 | Output enable, active low, registered |
| rd_n_o | output | 1 | Read strobe, active low, registered |
| m_valid_o | output | 1 | Stream valid, one cycle per captured word |
| m_data_o | output | DATA_W | Stream data |
| m_ready_i | input | 1 | Stream ready, consulted at burst start |

## Verification
The assertions assume that the watermark flag is truthful. It falls exactly when the bridge holds SLACK_WORDS words and rises only after a refill. They also assume that the sink keeps ready high from a granted start until select is released and the last valid beat has gone. Reset must be held for at least LATENCY+2 cycles. The bench's bridge model derives its flag from its own word count, which meets the first assumption. It refills only when it is empty, sometimes while the previous burst is still releasing the bus, and it lowers ready only when the bus is idle with no beat pending.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_RELEASE = 2'd3
  } fbr_state_e;
endpackage

// File: rtl/fbr_down_cnt.sv
module fbr_down_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)                       val_q <= '0;
    else if (load)                 val_q <= load_val;
    else if (dec && val_q != '0)   val_q <= val_q - 1'b1;
  end

  assign zero = (val_q == '0);
endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int LATENCY     = 2,
  parameter int SLACK_WORDS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wm_flag,
  input  logic sink_ready,
  output logic cs_n,
  output logic oe_n,
  output logic rd_n
);
  localparam int EXTRA_RD  = SLACK_WORDS - 1;
  localparam int CNT_MAX   = (EXTRA_RD > LATENCY) ? EXTRA_RD : LATENCY;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int DRAIN_LDI = (EXTRA_RD > 0) ? EXTRA_RD - 1 : 0;
  localparam int HOLD_LDI  = (LATENCY > 0) ? LATENCY - 1 : 0;
  localparam logic [CNT_W-1:0] DRAIN_LD = CNT_W'(DRAIN_LDI);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_LDI);

  fbr_state_e       st_q, st_d;
  logic             cs_q, oe_q, rd_q;
  logic             cs_d, oe_d, rd_d;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             has_drain;

  generate
    if (EXTRA_RD > 0) begin : g_drain
      assign has_drain = 1'b1;
    end else begin : g_nodrain
      assign has_drain = 1'b0;
    end
  endgenerate

  fbr_down_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  always_comb begin
    st_d     = st_q;
    cs_d     = cs_q;
    oe_d     = oe_q;
    rd_d     = rd_q;
    cnt_load = 1'b0;
    cnt_val  = HOLD_LD;
    cnt_dec  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wm_flag && sink_ready) begin
          st_d = ST_READ;
          cs_d = 1'b0;
          oe_d = 1'b0;
          rd_d = 1'b0;
        end
      end
      ST_READ: begin
        if (!wm_flag) begin
          cnt_load = 1'b1;
          if (has_drain) begin
            st_d    = ST_DRAIN;
            cnt_val = DRAIN_LD;
          end else begin
            st_d    = ST_RELEASE;
            rd_d    = 1'b1;
            cnt_val = HOLD_LD;
          end
        end
      end
      ST_DRAIN: begin
        if (cnt_zero) begin
          st_d     = ST_RELEASE;
          rd_d     = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = HOLD_LD;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (cnt_zero) begin
          st_d = ST_IDLE;
          cs_d = 1'b1;
          oe_d = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      cs_q <= 1'b1;
      oe_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      st_q <= st_d;
      cs_q <= cs_d;
      oe_q <= oe_d;
      rd_q <= rd_d;
    end
  end

  assign cs_n = cs_q;
  assign oe_n = oe_q;
  assign rd_n = rd_q;
endmodule

// File: rtl/fbr_lat_pipe.sv
module fbr_lat_pipe #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_taken,
  input  logic [DATA_W-1:0] bus_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [LATENCY-1:0] hist_q;

  generate
    for (genvar i = 0; i < LATENCY; i++) begin : g_hist
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) hist_q[0] <= 1'b0;
          else     hist_q[0] <= strobe_taken;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) hist_q[i] <= 1'b0;
          else     hist_q[i] <= hist_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= hist_q[LATENCY-1];
      if (hist_q[LATENCY-1]) out_data <= bus_data;
    end
  end
endmodule

// File: rtl/fbr_read_master.sv
module fbr_read_master #(
  parameter int DATA_W      = 16,
  parameter int LATENCY     = 2,
  parameter int SLACK_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wm_flag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              cs_n_o,
  output logic              oe_n_o,
  output logic              rd_n_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_ready_i
);
  logic cs_n, oe_n, rd_n, taken;

  fbr_ctrl #(.LATENCY(LATENCY), .SLACK_WORDS(SLACK_WORDS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wm_flag    (wm_flag_i),
    .sink_ready (m_ready_i),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .rd_n       (rd_n)
  );

  assign taken = ~cs_n & ~rd_n;

  fbr_lat_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_pipe (
    .clk          (clk),
    .rst          (rst),
    .strobe_taken (taken),
    .bus_data     (bus_data_i),
    .out_valid    (m_valid_o),
    .out_data     (m_data_o)
  );

  assign cs_n_o = cs_n;
  assign oe_n_o = oe_n;
  assign rd_n_o = rd_n;
endmodule

// File: rtl/fbr_read_master_chk.sv
module fbr_read_master_chk #(
  parameter int LATENCY = 2
) (
  input logic clk,
  input logic rst,
  input logic wm_flag_i,
  input logic cs_n_o,
  input logic oe_n_o,
  input logic rd_n_o,
  input logic m_valid_o,
  input logic m_ready_i
);
  logic [7:0] outstanding;
  logic [7:0] since_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
      since_rise  <= '0;
    end else begin
      outstanding <= outstanding + 8'(!cs_n_o && !rd_n_o) - 8'(m_valid_o);
      if (rd_n_o && !cs_n_o) since_rise <= since_rise + 1'b1;
      else                   since_rise <= '0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cs_n_o && oe_n_o && rd_n_o && !m_valid_o));

  p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> ($past(wm_flag_i) && $past(m_ready_i) && !rd_n_o && !oe_n_o));

  p_sink_ready_r2: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> m_ready_i);

  p_strobe_selected_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> (!cs_n_o && !oe_n_o));

  p_valid_has_source_r4: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> (outstanding != '0));

  p_inflight_bound_r4: assert property (@(posedge clk) disable iff (rst)
    outstanding <= 8'(LATENCY + 1));

  p_idle_drained_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_n_o && $past(cs_n_o)) |-> (outstanding == '0));

  p_release_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (since_rise == 8'(LATENCY) && oe_n_o));
endmodule

bind fbr_read_master fbr_read_master_chk #(.LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wm_flag_i (wm_flag_i),
  .cs_n_o    (cs_n_o),
  .oe_n_o    (oe_n_o),
  .rd_n_o    (rd_n_o),
  .m_valid_o (m_valid_o),
  .m_ready_i (m_ready_i)
);

// File: tb/fbr_read_master_bench.sv
module fbr_read_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int LAT   = 2;
  localparam int SLACK = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          m_ready = 1'b1;
  logic          cs_n, oe_n, rd_n, m_valid;
  logic [DW-1:0] m_data, bus_data;
  logic          wm_flag;

  // bridge model state
  int            count = 0;
  int            seq = 0;
  logic [DW-1:0] s1 = '0, bus_q = '0, exp_d = '0;
  logic          s1v = 1'b0, busv = 1'b0, exp_v = 1'b0;
  logic          fill_req = 1'b0, fill_ack = 1'b0;
  int            fill_size = 0;
  int            loaded = 0, received = 0;
  logic          smp_flag = 1'b0, smp_ready = 1'b0;
  logic          in_tail = 1'b0, tail_evt = 1'b0, hold_evt = 1'b0, over_evt = 1'b0;
  int            tail_pops = 0, tail_s = 0, hi_cnt = 0, hold_s = 0;

  int            checks = 0, errors = 0;
  logic          r1_done = 1'b0, prev_cs = 1'b1, final_chk = 1'b0, final_done = 1'b0;
  logic          timed_out = 1'b0;
  int            gap_run = 0, bursts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wm_flag  = (count > SLACK);
  assign bus_data = (!oe_n && !cs_n && busv) ? bus_q : 16'hDEAD;

  fbr_read_master #(.DATA_W(DW), .LATENCY(LAT), .SLACK_WORDS(SLACK)) u_fbr_read_master (
    .clk        (clk),
    .rst        (rst),
    .wm_flag_i  (wm_flag),
    .bus_data_i (bus_data),
    .cs_n_o     (cs_n),
    .oe_n_o     (oe_n),
    .rd_n_o     (rd_n),
    .m_valid_o  (m_valid),
    .m_data_o   (m_data),
    .m_ready_i  (m_ready)
  );

  function automatic logic [DW-1:0] word_of(int n);
    return DW'(n * 40503 + 7);
  endfunction

  // behavioural bridge: pops on a sampled strobe, word lands LAT edges later
  always @(posedge clk) begin
    int nc;
    logic taken;
    taken    = !cs_n && !rd_n;
    tail_evt <= 1'b0;
    hold_evt <= 1'b0;
    over_evt <= 1'b0;
    if (rst) begin
      count <= 0; s1v <= 1'b0; busv <= 1'b0; exp_v <= 1'b0;
      in_tail <= 1'b0; hi_cnt <= 0;
      fill_ack <= fill_req;
    end else begin
      smp_flag  <= wm_flag;
      smp_ready <= m_ready;
      nc = count;
      if (taken) begin
        if (count == 0) over_evt <= 1'b1;
        else nc = nc - 1;
        s1  <= word_of(seq);
        seq <= seq + 1;
      end
      s1v   <= taken;
      bus_q <= s1;
      busv  <= s1v;
      exp_v <= busv;
      exp_d <= bus_q;
      if (fill_req != fill_ack) begin
        nc = nc + fill_size;
        loaded <= loaded + fill_size;
      end
      fill_ack <= fill_req;
      count <= nc;
      // tail accounting for R5
      if (taken && !in_tail && !wm_flag) begin
        in_tail   <= 1'b1;
        tail_pops <= 1;
      end else if (taken && in_tail) begin
        tail_pops <= tail_pops + 1;
      end else if (!taken && in_tail) begin
        in_tail  <= 1'b0;
        tail_evt <= 1'b1;
        tail_s   <= tail_pops;
      end
      // select hold accounting for R6
      if (!cs_n && rd_n) hi_cnt <= hi_cnt + 1;
      else begin
        if (cs_n && hi_cnt != 0) begin
          hold_evt <= 1'b1;
          hold_s   <= hi_cnt;
        end
        hi_cnt <= 0;
      end
    end
  end

  // all checks, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst && !final_done) begin
      if (!r1_done) begin
        checks++;
        if (!(cs_n && oe_n && rd_n && !m_valid)) begin
          errors++;
          $display("FAIL R1 reset state cs=%b oe=%b rd=%b v=%b expected 1 1 1 0", cs_n, oe_n, rd_n, m_valid);
        end
        r1_done = 1'b1;
      end
      if (!rd_n) begin
        checks++;
        if (cs_n || oe_n) begin
          errors++;
          $display("FAIL R3 strobe low with cs=%b oe=%b expected 0 0", cs_n, oe_n);
        end
      end
      checks++;
      if (m_valid !== exp_v) begin
        errors++;
        $display("FAIL R4 m_valid=%b expected %b", m_valid, exp_v);
      end
      if (exp_v) begin
        checks++;
        received++;
        if (m_data !== exp_d) begin
          errors++;
          $display("FAIL R7 m_data=%h expected %h", m_data, exp_d);
        end
      end
      if (prev_cs && !cs_n) begin
        checks++;
        if (!(smp_flag && smp_ready)) begin
          errors++;
          $display("FAIL R2 burst start with flag=%b ready=%b expected 1 1", smp_flag, smp_ready);
        end
        if (bursts > 0) begin
          checks++;
          if (gap_run < 1) begin
            errors++;
            $display("FAIL R8 idle gap %0d expected >= 1", gap_run);
          end
        end
        bursts++;
      end
      if (cs_n) gap_run++; else gap_run = 0;
      if (tail_evt) begin
        checks++;
        if (tail_s != SLACK) begin
          errors++;
          $display("FAIL R5 tail strobes %0d expected %0d", tail_s, SLACK);
        end
      end
      if (hold_evt) begin
        checks++;
        if (hold_s != LAT) begin
          errors++;
          $display("FAIL R6 select hold %0d expected %0d", hold_s, LAT);
        end
      end
      if (over_evt) begin
        checks++;
        errors++;
        $display("FAIL R7 strobe on empty bridge count=%0d expected >0", count);
      end
      prev_cs = cs_n;
    end
    if (final_chk && !final_done) begin
      checks++;
      if (received != loaded) begin
        errors++;
        $display("FAIL R7 words received %0d expected %0d", received, loaded);
      end
      checks++;
      if (seq != loaded) begin
        errors++;
        $display("FAIL R7 words strobed %0d expected %0d", seq, loaded);
      end
      if (timed_out) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired, got hang expected completion");
      end
      final_done = 1'b1;
    end
  end

  task automatic fill(input int n);
    @(negedge clk);
    fill_size = n;
    fill_req  = ~fill_req;
    wait (fill_ack == fill_req);
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (count == 0 && cs_n && !m_valid && !exp_v) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    fork
      begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R2, R4, R5, R6: single bursts of assorted sizes
        fill(3);  wait_idle();
        fill(4);  wait_idle();
        fill(5);  wait_idle();
        fill(17); wait_idle();
        // R8: refill while the previous burst is still releasing the bus
        fill(6);
        wait (count == 0);
        fill(9);
        wait (count == 0);
        fill(3);
        wait_idle();
        // R2: flag high with sink not ready must not start a burst
        m_ready = 1'b0;
        fill(8);
        repeat (12) @(negedge clk);
        m_ready = 1'b1;
        wait_idle();
        // R7: long burst then many short ones back to back
        fill(40); wait_idle();
        for (int k = 0; k < 6; k++) begin
          fill(3 + k);
          wait (count == 0);
        end
        wait_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    @(negedge clk);
    final_chk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule